// File: doc/BRIEF.md
# Command Response Receiver with Halfword Readout

This block listens to the serial command line of a memory card after the host has sent a command. It waits for the card's start bit and shifts the response in, most significant bit first. It packs the bits into 16-bit halfwords in a small FIFO, where software reads them one per pop. Every bit is sampled only on cycles that carry the card-clock tick strobe. All logic runs on the system clock.

A 3-bit format code, given when the command is issued, selects the capture length. A short response is 48 bits and yields three halfwords. A long response is 136 bits and yields nine halfwords, the last one holding only eight bits. Code 0 means the command expects no response.

When the capture is complete the block pulses a response-end event. If no start bit arrives within the configured number of ticks, it sets a sticky timeout flag and still raises the event. If a busy wait was requested, the block then watches the card's busy line and pulses a programming-done event once the card releases it.

Top module: `cmd_resp_rx`

## Requirements
- R1: Format code 2 selects a 136-bit capture. Codes 1, 3 and every code from 4 to 7 select a 48-bit capture. Code 0 captures nothing: the block raises the response-end event and the FIFO stays empty.
- R2: Capture begins with the first 0 sampled on `cmdIn` in a tick cycle after `issue`. That start bit becomes bit 15 of the first halfword, and the 1 bits sampled before it are discarded.
- R3: A short response fills exactly three halfwords. Bits arrive MSB first, so halfword k holds frame bits [47-16k : 32-16k], and halfword 0 is popped first.
- R4: A long response fills exactly nine halfwords. The first eight are the frame's bits in 16-bit slices, most significant slice first. The ninth holds the last 8 frame bits in [15:8], with zeros in [7:0].
- R5: `respEnd` is a one-cycle pulse. It rises once per response, when all of that response's halfwords are already readable.
- R6: If no start bit is sampled within TIMEOUT_TICKS (64) ticks after `issue`, `respTimeout` goes high and `respEnd` pulses with the FIFO empty. `respTimeout` stays high until the next `issue`.
- R7: While the FIFO is empty, `popData` reads 0 and `fifoEmpty` is 1. A pop in that state changes nothing, and the next response reads back intact.
- R8: If `busyWait` was set at issue, then after `respEnd` the block pulses `progDone` for one cycle. The pulse comes on the first tick cycle in which `busyIn` is 1 (card released), and never while `busyIn` is 0. Without `busyWait`, `progDone` stays low.
- R9: `issue` discards any unread halfwords and clears `respTimeout`. On the next cycle the FIFO is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Card-clock sampling strobe, one system cycle wide |
| cmdIn | input | 1 | Serial command line from the card |
| issue | input | 1 | Command just sent: arm the receiver |
| fmtSel | input | 3 | Response format code, sampled with `issue` |
| busyWait | input | 1 | Wait for busy release after the response, sampled with `issue` |
| busyIn | input | 1 | Card busy line (0 = busy) |
| popReq | input | 1 | Pop one halfword from the response FIFO |
| popData | output | 16 | Halfword at the FIFO head, 0 when empty |
| fifoEmpty | output | 1 | FIFO holds no halfword |
| respEnd | output | 1 | Response-end event pulse |
| respTimeout | output | 1 | Sticky response timeout status |
| progDone | output | 1 | Busy release (programming done) event pulse |

## Verification
The assertions check on every cycle that both events are single-cycle pulses, and that an empty FIFO reads zero. They also check that `issue` leaves the FIFO empty with the timeout cleared, that the timeout is sticky, that it rises together with `respEnd` on an empty FIFO, and that `progDone` follows a tick on which the busy line was released. The bit packing can only be shown by the bench's scenarios. That covers MSB-first order, the halfword count for each format code, the left-aligned ninth halfword and the discarding of idle bits before the start bit. The bench scenarios also show the timing of the timeout window and that a pop on an empty FIFO has no effect on the next response.

// File: rtl/cmd_resp_rx_pkg.sv
package cmd_resp_rx_pkg;

  localparam logic [2:0] FMT_NONE = 3'd0;
  localparam logic [2:0] FMT_LONG = 3'd2;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HUNT,
    ST_SHIFT,
    ST_FLUSH,
    ST_BUSY
  } rxState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic clear;   // drop FIFO contents and partial halfword
    logic shift;   // take one bit from the command line
    logic flush;   // push the partial halfword, left-aligned
  } rxStrobe_t;

endpackage

// File: rtl/cmd_resp_rx_ctrl.sv
module cmd_resp_rx_ctrl
  import cmd_resp_rx_pkg::*;
#(
  parameter int SHORT_BITS    = 48,
  parameter int LONG_BITS     = 136,
  parameter int TIMEOUT_TICKS = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       cmdIn,
  input  logic       issue,
  input  logic [2:0] fmtSel,
  input  logic       busyWait,
  input  logic       busyIn,
  output rxStrobe_t  strobe,
  output logic       respEnd,
  output logic       respTimeout,
  output logic       progDone
);

  localparam int BITS_W = $clog2(LONG_BITS + 1);
  localparam int HUNT_W = $clog2(TIMEOUT_TICKS + 1);
  localparam logic [HUNT_W-1:0] HUNT_LAST = HUNT_W'(TIMEOUT_TICKS - 1);

  rxState_t          state;
  logic [BITS_W-1:0] bitsLeft;
  logic [HUNT_W-1:0] huntCnt;
  logic              busyReq;
  logic [BITS_W-1:0] frameLen;

  always_comb begin
    frameLen = (fmtSel == FMT_LONG) ? BITS_W'(LONG_BITS) : BITS_W'(SHORT_BITS);
  end

  always_comb begin
    strobe.clear = issue;
    strobe.shift = !issue && tick &&
                   ((state == ST_HUNT && !cmdIn) || state == ST_SHIFT);
    strobe.flush = !issue && (state == ST_FLUSH);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      bitsLeft    <= '0;
      huntCnt     <= '0;
      busyReq     <= 1'b0;
      respEnd     <= 1'b0;
      respTimeout <= 1'b0;
      progDone    <= 1'b0;
    end else begin
      respEnd  <= 1'b0;
      progDone <= 1'b0;
      if (issue) begin
        state       <= (fmtSel == FMT_NONE) ? ST_FLUSH : ST_HUNT;
        bitsLeft    <= frameLen;
        huntCnt     <= '0;
        busyReq     <= busyWait;
        respTimeout <= 1'b0;
      end else begin
        unique case (state)
          ST_HUNT: begin
            if (tick) begin
              if (!cmdIn) begin
                bitsLeft <= bitsLeft - 1'b1;
                state    <= ST_SHIFT;
              end else if (huntCnt == HUNT_LAST) begin
                respTimeout <= 1'b1;
                respEnd     <= 1'b1;
                state       <= ST_IDLE;
              end else begin
                huntCnt <= huntCnt + 1'b1;
              end
            end
          end
          ST_SHIFT: begin
            if (tick) begin
              bitsLeft <= bitsLeft - 1'b1;
              if (bitsLeft == BITS_W'(1)) state <= ST_FLUSH;
            end
          end
          ST_FLUSH: begin
            respEnd <= 1'b1;
            state   <= busyReq ? ST_BUSY : ST_IDLE;
          end
          ST_BUSY: begin
            if (tick && busyIn) begin
              progDone <= 1'b1;
              state    <= ST_IDLE;
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

endmodule

// File: rtl/cmd_resp_rx_dpath.sv
module cmd_resp_rx_dpath
  import cmd_resp_rx_pkg::*;
#(
  parameter int HW_W       = 16,
  parameter int FIFO_DEPTH = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  rxStrobe_t       strobe,
  input  logic            bitIn,
  input  logic            popReq,
  output logic [HW_W-1:0] popData,
  output logic            fifoEmpty
);

  localparam int CNT_W = $clog2(HW_W);
  localparam int PTR_W = $clog2(FIFO_DEPTH);
  localparam int LVL_W = PTR_W + 1;

  logic [HW_W-1:0]  shiftReg;
  logic [CNT_W-1:0] bitCnt;
  logic [HW_W-1:0]  mem [FIFO_DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [LVL_W-1:0] level;

  logic             push, pop;
  logic [HW_W-1:0]  pushData;
  logic [HW_W-1:0]  nextShift;

  always_comb begin
    nextShift = {shiftReg[HW_W-2:0], bitIn};
    push      = 1'b0;
    pushData  = nextShift;
    if (strobe.shift && bitCnt == CNT_W'(HW_W - 1)) begin
      push = 1'b1;
    end else if (strobe.flush && bitCnt != '0) begin
      push     = 1'b1;
      pushData = shiftReg << (HW_W - int'(bitCnt));
    end
  end

  assign fifoEmpty = (level == '0);
  assign pop       = popReq && !fifoEmpty && !strobe.clear;
  assign popData   = fifoEmpty ? '0 : mem[rdPtr];

  // Bit packer
  always_ff @(posedge clk) begin
    if (!rst_n || strobe.clear || strobe.flush) begin
      shiftReg <= '0;
      bitCnt   <= '0;
    end else if (strobe.shift) begin
      shiftReg <= nextShift;
      bitCnt   <= bitCnt + 1'b1;
    end
  end

  // Halfword FIFO storage
  generate
    for (genvar e = 0; e < FIFO_DEPTH; e++) begin : g_entry
      always_ff @(posedge clk) begin
        if (push && wrPtr == PTR_W'(e)) mem[e] <= pushData;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n || strobe.clear) begin
      wrPtr <= '0;
      rdPtr <= '0;
      level <= '0;
    end else begin
      if (push) wrPtr <= wrPtr + 1'b1;
      if (pop)  rdPtr <= rdPtr + 1'b1;
      case ({push, pop})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end

endmodule

// File: rtl/cmd_resp_rx.sv
module cmd_resp_rx
  import cmd_resp_rx_pkg::*;
#(
  parameter int SHORT_BITS    = 48,
  parameter int LONG_BITS     = 136,
  parameter int TIMEOUT_TICKS = 64,
  parameter int HW_W          = 16,
  parameter int FIFO_DEPTH    = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  input  logic            cmdIn,
  input  logic            issue,
  input  logic [2:0]      fmtSel,
  input  logic            busyWait,
  input  logic            busyIn,
  input  logic            popReq,
  output logic [HW_W-1:0] popData,
  output logic            fifoEmpty,
  output logic            respEnd,
  output logic            respTimeout,
  output logic            progDone
);

  rxStrobe_t strobe;

  cmd_resp_rx_ctrl #(
    .SHORT_BITS   (SHORT_BITS),
    .LONG_BITS    (LONG_BITS),
    .TIMEOUT_TICKS(TIMEOUT_TICKS)
  ) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .cmdIn      (cmdIn),
    .issue      (issue),
    .fmtSel     (fmtSel),
    .busyWait   (busyWait),
    .busyIn     (busyIn),
    .strobe     (strobe),
    .respEnd    (respEnd),
    .respTimeout(respTimeout),
    .progDone   (progDone)
  );

  cmd_resp_rx_dpath #(
    .HW_W      (HW_W),
    .FIFO_DEPTH(FIFO_DEPTH)
  ) u_dpath (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobe   (strobe),
    .bitIn    (cmdIn),
    .popReq   (popReq),
    .popData  (popData),
    .fifoEmpty(fifoEmpty)
  );

endmodule

// File: rtl/cmd_resp_rx_chk.sv
module cmd_resp_rx_chk #(
  parameter int HW_W = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic            tick,
  input logic            issue,
  input logic            busyIn,
  input logic [HW_W-1:0] popData,
  input logic            fifoEmpty,
  input logic            respEnd,
  input logic            respTimeout,
  input logic            progDone
);

  AST_RESP_END_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    respEnd |=> !respEnd); // R5

  AST_PROG_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    progDone |=> !progDone); // R8

  AST_PROG_AFTER_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    progDone |-> $past(tick && busyIn)); // R8

  AST_EMPTY_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    fifoEmpty |-> (popData == '0)); // R7

  AST_TIMEOUT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (respTimeout && !issue) |=> respTimeout); // R6

  AST_TIMEOUT_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(respTimeout) |-> (fifoEmpty && respEnd)); // R6

  AST_ISSUE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    issue |=> (fifoEmpty && !respTimeout)); // R9

endmodule

bind cmd_resp_rx cmd_resp_rx_chk #(.HW_W(HW_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .tick       (tick),
  .issue      (issue),
  .busyIn     (busyIn),
  .popData    (popData),
  .fifoEmpty  (fifoEmpty),
  .respEnd    (respEnd),
  .respTimeout(respTimeout),
  .progDone   (progDone)
);

// File: tb/tb_cmd_resp_rx.sv
`timescale 1ns/1ps
module tb_cmd_resp_rx;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick;
  logic        cmdIn = 1'b1;
  logic        issue = 1'b0;
  logic [2:0]  fmtSel = 3'd0;
  logic        busyWait = 1'b0;
  logic        busyIn = 1'b1;
  logic        popReq = 1'b0;
  logic [15:0] popData;
  logic        fifoEmpty, respEnd, respTimeout, progDone;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  logic [1:0] tickDiv;

  always #2.5 clk = ~clk;

  always_ff @(posedge clk) begin
    if (!rst_n) tickDiv <= '0;
    else        tickDiv <= tickDiv + 1'b1;
  end
  assign tick = (tickDiv == 2'd3);

  cmd_resp_rx dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cmdIn(cmdIn), .issue(issue),
    .fmtSel(fmtSel), .busyWait(busyWait), .busyIn(busyIn), .popReq(popReq),
    .popData(popData), .fifoEmpty(fifoEmpty), .respEnd(respEnd),
    .respTimeout(respTimeout), .progDone(progDone)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog: run hung, actual %0d cycles expected < 150000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic issueCmd(input logic [2:0] fmt, input logic bw);
    fmtSel = fmt; busyWait = bw; issue = 1'b1;
    @(negedge clk);
    issue = 1'b0;
  endtask

  task automatic cardBit(input logic b);
    cmdIn = b;
    while (!tick) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic waitEnd(input int limit, output bit seen, output int waited);
    seen = 0; waited = 0;
    while (!seen && waited < limit) begin
      if (respEnd) seen = 1;
      else begin @(negedge clk); waited++; end
    end
  endtask

  task automatic popCheck(input string tag, input logic [15:0] exp);
    chk(tag, {16'h0, popData}, {16'h0, exp});
    popReq = 1'b1;
    @(negedge clk);
    popReq = 1'b0;
  endtask

  task automatic runShort(input string tag, input logic [2:0] fmt,
                          input logic [47:0] frame, input int idle);
    bit seen; int w;
    issueCmd(fmt, 1'b0);
    for (int i = 0; i < idle; i++) cardBit(1'b1);
    for (int i = 47; i >= 0; i--) cardBit(frame[i]);
    cmdIn = 1'b1;
    waitEnd(100, seen, w);
    chk({tag, " R5 respEnd seen"}, 32'(seen), 32'd1);
    for (int k = 0; k < 3; k++) popCheck({tag, " R3 halfword"}, frame[47-16*k -: 16]);
    chk({tag, " R1 exactly three halfwords"}, 32'(fifoEmpty), 32'd1);
  endtask

  // R1 R2 R3 R5 R8: short response after idle ones, no busy wait
  task automatic testShortBasic();
    int pd = 0;
    runShort("short fmt1", 3'd1, {2'b00, 6'h11, 32'hA5C3_1E7B, 7'h55, 1'b1}, 5);
    for (int i = 0; i < 30; i++) begin
      if (progDone) pd++;
      @(negedge clk);
    end
    chk("R8 no progDone without busy wait", 32'(pd), 32'd0);
  endtask

  // R1: code 3 and a reserved code also give 48-bit captures
  task automatic testShortOtherCodes();
    runShort("short fmt3 R2 no idle", 3'd3, {2'b00, 6'h3F, 32'h00FF_8001, 7'h7F, 1'b1}, 0);
    runShort("short fmt6", 3'd6, {2'b00, 6'h2A, 32'h1234_5678, 7'h0C, 1'b1}, 2);
  endtask

  // R1 R4: long response
  task automatic testLong();
    bit seen; int w;
    logic [135:0] frame;
    frame = {8'h3F, 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3211};
    issueCmd(3'd2, 1'b0);
    for (int i = 0; i < 3; i++) cardBit(1'b1);
    for (int i = 135; i >= 0; i--) cardBit(frame[i]);
    cmdIn = 1'b1;
    waitEnd(100, seen, w);
    chk("long R5 respEnd seen", 32'(seen), 32'd1);
    for (int k = 0; k < 8; k++) popCheck("long R4 halfword", frame[135-16*k -: 16]);
    popCheck("long R4 left-aligned tail", {frame[7:0], 8'h00});
    chk("long R4 exactly nine halfwords", 32'(fifoEmpty), 32'd1);
  endtask

  // R1: no-response code
  task automatic testNoResp();
    bit seen; int w;
    issueCmd(3'd0, 1'b0);
    waitEnd(20, seen, w);
    chk("R1 code 0 raises respEnd", 32'(seen), 32'd1);
    chk("R1 code 0 leaves FIFO empty", 32'(fifoEmpty), 32'd1);
    chk("R1 code 0 no timeout", 32'(respTimeout), 32'd0);
  endtask

  // R6 R9: timeout, sticky, cleared by issue
  task automatic testTimeout();
    bit seen; int w;
    issueCmd(3'd1, 1'b0);
    cmdIn = 1'b1;
    waitEnd(400, seen, w);
    chk("R6 respEnd on timeout", 32'(seen), 32'd1);
    chk("R6 not before 64 ticks", 32'(w >= 248), 32'd1);
    chk("R6 within 64 ticks", 32'(w <= 262), 32'd1);
    chk("R6 timeout flag", 32'(respTimeout), 32'd1);
    chk("R6 FIFO empty on timeout", 32'(fifoEmpty), 32'd1);
    repeat (20) @(negedge clk);
    chk("R6 timeout sticky", 32'(respTimeout), 32'd1);
    issueCmd(3'd0, 1'b0);
    chk("R9 issue clears timeout", 32'(respTimeout), 32'd0);
    repeat (4) @(negedge clk);
  endtask

  // R7: pop on empty
  task automatic testEmptyPop();
    chk("R7 empty reads zero", {16'h0, popData}, 32'h0);
    popReq = 1'b1;
    @(negedge clk);
    popReq = 1'b0;
    chk("R7 still empty after pop", 32'(fifoEmpty), 32'd1);
    chk("R7 still zero after pop", {16'h0, popData}, 32'h0);
    runShort("R7 after empty pop", 3'd1, {2'b00, 6'h05, 32'hDEAD_BEEF, 7'h21, 1'b1}, 1);
  endtask

  // R8: busy wait
  task automatic testBusy();
    bit seen; int w; int pd = 0; logic [47:0] frame;
    frame = {2'b00, 6'h07, 32'h0BAD_F00D, 7'h11, 1'b1};
    busyIn = 1'b0;
    issueCmd(3'd1, 1'b1);
    for (int i = 47; i >= 0; i--) cardBit(frame[i]);
    cmdIn = 1'b1;
    waitEnd(100, seen, w);
    chk("busy R5 respEnd seen", 32'(seen), 32'd1);
    for (int i = 0; i < 30; i++) begin
      if (progDone) pd++;
      @(negedge clk);
    end
    chk("R8 no progDone while busy", 32'(pd), 32'd0);
    busyIn = 1'b1;
    seen = 0;
    for (int i = 0; i < 20 && !seen; i++) begin
      if (progDone) seen = 1; else @(negedge clk);
    end
    chk("R8 progDone after release", 32'(seen), 32'd1);
    @(negedge clk);
    chk("R8 progDone single cycle", 32'(progDone), 32'd0);
    for (int k = 0; k < 3; k++) popCheck("busy R3 halfword", frame[47-16*k -: 16]);
  endtask

  // R9: issue drops unread data
  task automatic testIssueFlush();
    bit seen; int w; logic [47:0] frame;
    frame = {2'b00, 6'h19, 32'hCAFE_0001, 7'h33, 1'b1};
    issueCmd(3'd1, 1'b0);
    for (int i = 47; i >= 0; i--) cardBit(frame[i]);
    cmdIn = 1'b1;
    waitEnd(100, seen, w);
    chk("R9 data present before issue", 32'(fifoEmpty), 32'd0);
    issueCmd(3'd0, 1'b0);
    chk("R9 issue empties FIFO", 32'(fifoEmpty), 32'd1);
    chk("R9 empty after issue reads zero", {16'h0, popData}, 32'h0);
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R7 reset empty", 32'(fifoEmpty), 32'd1);
    chk("R5 reset no respEnd", 32'(respEnd), 32'd0);
    chk("R6 reset no timeout", 32'(respTimeout), 32'd0);
    chk("R8 reset no progDone", 32'(progDone), 32'd0);
    testShortBasic();
    testShortOtherCodes();
    testLong();
    testNoResp();
    testTimeout();
    testEmptyPop();
    testBusy();
    testIssueFlush();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule